// File: doc/BRIEF.md
# Low-Power-Aware Watchdog Timer

This block is a watchdog counter for a CPU subsystem that can enter two low-power states. The counter advances on one of two tick enables, chosen by a source select: a system-clock tick or a low-speed oscillator tick. Software must restart it before it reaches a programmed limit. If it does not, the block raises a one-cycle reset request and the count wraps to zero.

Two status inputs report the CPU power state. While the deep-sleep input is high, the counter is frozen and keeps its value. When that input drops, a blanking interval follows, measured in low-speed ticks, and the count stays frozen until the interval has run out. A light-sleep input also freezes the count, but only when a configuration bit allows this. Counting resumes at once when that input drops. The deep-sleep input wins when both are high, so the blanking interval still applies on wake-up.

Top module: `wdog_lp_top`

## Requirements
- R1: After reset the request output is low and the count is zero. With limit L and a tick on every cycle, the first request is seen in the (L+1)-th cycle after reset is released.
- R2: `src_sel_i` = 0 makes the counter advance on `sys_tick_i`, and `src_sel_i` = 1 makes it advance on `lsosc_tick_i`. Ticks on the unselected input have no effect.
- R3: A selected tick that arrives while the count equals `limit_i` sets the count to zero and drives `reset_req_o` high for exactly the following cycle. From zero, L+1 ticks produce one request.
- R4: A restart strobe clears the count to zero whenever `stop_i` is low, including during the post-wake blanking interval. The strobe has priority over a tick in the same cycle. A restart while `stop_i` is high is ignored.
- R5: While `stop_i` is high the count does not change. On wake-up, counting continues from the value held at entry to the stop state.
- R6: The cycle in which `stop_i` falls loads a blanking counter with the resume delay. The count stays frozen until that many low-speed ticks have been seen after the fall, and it advances from the next selected tick onward.
- R7: With `halt_freeze_en_i` = 1, the count is frozen while `halt_i` is high for either tick source. It advances again on the first selected tick after `halt_i` falls, with no blanking interval.
- R8: With `halt_freeze_en_i` = 0, `halt_i` has no effect and the counter keeps running.
- R9: When `stop_i` and `halt_i` are high together, the stop state governs. Releasing both applies the full blanking interval.
- R10: The resume delay is a parameter in low-speed ticks. At elaboration it is limited to the range 17 to 67, and a value outside the range takes the nearer bound. The default is 34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single synchronous clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_tick_i | input | 1 | System-clock tick enable |
| lsosc_tick_i | input | 1 | Low-speed oscillator tick enable |
| src_sel_i | input | 1 | Count source: 0 system tick, 1 low-speed tick |
| stop_i | input | 1 | CPU deep-sleep status |
| halt_i | input | 1 | CPU light-sleep status |
| halt_freeze_en_i | input | 1 | Allows light-sleep to freeze the count |
| restart_i | input | 1 | Software restart strobe |
| limit_i | input | CNT_W | Overflow limit |
| reset_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach from the ports is a restart or a held count landing inside the post-wake blanking interval. Nothing visible marks that window, so its edges show only as a shift in when the next request fires. The stimulus primes the count to a known value with a restart and a fixed number of ticks, then enters and leaves the stop state with a low-speed tick on every cycle. It then measures the cycle of the first request after wake-up, and the bench computes that cycle arithmetically. A second instance built with an out-of-range delay runs alongside the first and is checked against the clamped bound in the same scenarios.

// File: rtl/wdog_lp_pkg.sv
package wdog_lp_pkg;

    typedef enum logic {
        SRC_SYS = 1'b0,
        SRC_LS  = 1'b1
    } wdog_src_e;

    function automatic int unsigned clamp_ticks(int unsigned req, int unsigned lo, int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/wdog_lp_gate.sv
module wdog_lp_gate
    import wdog_lp_pkg::*;
(
    input  logic stop_i,
    input  logic blank_i,
    input  logic halt_i,
    input  logic halt_freeze_en_i,
    input  logic src_sel_i,
    input  logic sys_tick_i,
    input  logic lsosc_tick_i,
    output logic tick_o,
    output logic freeze_o
);
    wdog_src_e src;

    always_comb begin
        src      = wdog_src_e'(src_sel_i);
        tick_o   = (src == SRC_LS) ? lsosc_tick_i : sys_tick_i;
        // deep sleep and its blanking tail dominate; light sleep only when allowed
        freeze_o = stop_i | blank_i | (halt_i & halt_freeze_en_i);
    end
endmodule

// File: rtl/wdog_lp_resume.sv
module wdog_lp_resume #(
    parameter int unsigned BLK_W     = 7,
    parameter int unsigned RES_TICKS = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic lsosc_tick_i,
    output logic blank_o
);
    localparam logic [BLK_W-1:0] LOAD = BLK_W'(RES_TICKS);

    typedef struct packed {
        logic             stop_seen;
        logic [BLK_W-1:0] left;
    } res_st_t;

    res_st_t st_d, st_q;
    logic    wake;

    always_comb begin
        wake    = st_q.stop_seen & ~stop_i;
        blank_o = wake | (st_q.left != '0);
        st_d           = st_q;
        st_d.stop_seen = stop_i;
        if (stop_i) begin
            st_d.left = '0;
        end else if (wake) begin
            st_d.left = LOAD;
        end else if ((st_q.left != '0) && lsosc_tick_i) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a wake-up cycle arms the blanking counter with the full delay
    p_load_on_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop_seen && !stop_i) |=> (st_q.left == LOAD));

    // R10: the blanking counter never exceeds the clamped delay
    p_left_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= LOAD);
endmodule

// File: rtl/wdog_lp_counter.sv
module wdog_lp_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             freeze_i,
    input  logic             restart_i,
    input  logic             stop_i,
    input  logic             halt_gate_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (restart_i && !stop_i) begin
            st_d.cnt = '0;
        end else if (!freeze_i && tick_i) begin
            if (st_q.cnt == limit_i) begin
                st_d.cnt = '0;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R5: deep sleep keeps the count unchanged
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> $stable(st_q.cnt));

    // R4: an accepted restart leaves a zero count and no request
    p_restart_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !stop_i) |=> (st_q.cnt == '0 && !st_q.req));

    // R7: an enabled light sleep holds the count
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_gate_i && !restart_i) |=> $stable(st_q.cnt));

    // R3: a request always coincides with a wrapped count
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> (st_q.cnt == '0));
endmodule

// File: rtl/wdog_lp_top.sv
module wdog_lp_top #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned RES_MIN      = 17,
    parameter int unsigned RES_MAX      = 67,
    parameter int unsigned RESUME_TICKS = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_tick_i,
    input  logic             lsosc_tick_i,
    input  logic             src_sel_i,
    input  logic             stop_i,
    input  logic             halt_i,
    input  logic             halt_freeze_en_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             reset_req_o
);
    localparam int unsigned RES_EFF = wdog_lp_pkg::clamp_ticks(RESUME_TICKS, RES_MIN, RES_MAX);
    localparam int unsigned BLK_W   = $clog2(RES_MAX + 1);

    logic blank;
    logic tick;
    logic freeze;
    logic halt_gate;

    assign halt_gate = halt_i & halt_freeze_en_i;

    wdog_lp_resume #(
        .BLK_W     (BLK_W),
        .RES_TICKS (RES_EFF)
    ) u_resume (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_i       (stop_i),
        .lsosc_tick_i (lsosc_tick_i),
        .blank_o      (blank)
    );

    wdog_lp_gate u_gate (
        .stop_i           (stop_i),
        .blank_i          (blank),
        .halt_i           (halt_i),
        .halt_freeze_en_i (halt_freeze_en_i),
        .src_sel_i        (src_sel_i),
        .sys_tick_i       (sys_tick_i),
        .lsosc_tick_i     (lsosc_tick_i),
        .tick_o           (tick),
        .freeze_o         (freeze)
    );

    wdog_lp_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .freeze_i    (freeze),
        .restart_i   (restart_i),
        .stop_i      (stop_i),
        .halt_gate_i (halt_gate),
        .limit_i     (limit_i),
        .req_o       (reset_req_o)
    );

    // R9: while deep sleep is active the blanking path reports frozen
    p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> freeze);
endmodule

// File: tb/wdog_lp_top_bench.sv
module wdog_lp_top_bench;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_t = 1'b1, ls_t = 1'b1, src = 1'b0;
    logic          stop = 1'b0, halt = 1'b0, hfe = 1'b0, restart = 1'b0;
    logic [CW-1:0] limit = '0;
    logic          req0, req1;

    always #10 clk = ~clk;

    wdog_lp_top #(.CNT_W(CW)) u_wdog_lp_top (
        .clk(clk), .rst_n(rst_n), .sys_tick_i(sys_t), .lsosc_tick_i(ls_t),
        .src_sel_i(src), .stop_i(stop), .halt_i(halt), .halt_freeze_en_i(hfe),
        .restart_i(restart), .limit_i(limit), .reset_req_o(req0));

    wdog_lp_top #(.CNT_W(CW), .RESUME_TICKS(5)) u_wdog_lp_top_lo (
        .clk(clk), .rst_n(rst_n), .sys_tick_i(sys_t), .lsosc_tick_i(ls_t),
        .src_sel_i(src), .stop_i(stop), .halt_i(halt), .halt_freeze_en_i(hfe),
        .restart_i(restart), .limit_i(limit), .reset_req_o(req1));

    int    n_chk = 0, n_fail = 0;
    string cur_tag = "R1";
    bit    cmp_en = 0;
    bit    done = 0;
    int    cyc = 0, sys_per = 1, ls_per = 1;
    int    pc0, pc1, f0, f1, idx;

    int    m_cnt [2];
    int    m_blk [2];
    bit    m_sp  [2];
    bit    m_req [2];
    int    m_dly [2] = '{34, 17};

    task automatic check(int act, int exp, string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model built from the requirements
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            bit wake, frz, tk;
            if (!rst_n) begin
                m_cnt[k] = 0; m_blk[k] = 0; m_sp[k] = 0; m_req[k] = 0;
            end else begin
                wake = m_sp[k] && !stop;
                frz  = stop || wake || (m_blk[k] != 0) || (halt && hfe);
                tk   = src ? ls_t : sys_t;
                m_req[k] = 0;
                if (restart && !stop) m_cnt[k] = 0;
                else if (!frz && tk) begin
                    if (m_cnt[k] == int'(limit)) begin m_cnt[k] = 0; m_req[k] = 1; end
                    else m_cnt[k] = (m_cnt[k] + 1) % (1 << CW);
                end
                if (stop) m_blk[k] = 0;
                else if (wake) m_blk[k] = m_dly[k];
                else if (m_blk[k] != 0 && ls_t) m_blk[k] = m_blk[k] - 1;
                m_sp[k] = stop;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check(int'(req0), int'(m_req[0]), cur_tag);
            check(int'(req1), int'(m_req[1]), "R10");
        end
    end

    task automatic clr_stats();
        pc0 = 0; pc1 = 0; f0 = -1; f1 = -1; idx = 0;
    endtask

    task automatic drive_cycles(int n);
        repeat (n) begin
            @(negedge clk);
            idx++;
            if (req0) begin pc0++; if (f0 < 0) f0 = idx; end
            if (req1) begin pc1++; if (f1 < 0) f1 = idx; end
            sys_t = (sys_per != 0) && (cyc % sys_per == 0);
            ls_t  = (ls_per != 0) && (cyc % ls_per == 0);
            cyc++;
        end
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        drive_cycles(1);
        restart = 1'b0;
    endtask

    task automatic prime(int k);
        limit = 4'd7; src = 1'b0; sys_per = 1; ls_per = 1;
        pulse_restart();
        drive_cycles(k);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(int'(req0), 0, "R1");
        check(int'(req1), 0, "R1");
        limit = 4'd2;
        rst_n = 1'b1;
        cmp_en = 1;
        clr_stats();
        drive_cycles(10);
        check(f0, 3, "R1");

        cur_tag = "R3";
        for (int l = 0; l < 8; l++) begin
            for (int sp = 1; sp <= 2; sp++) begin
                limit = l[CW-1:0]; sys_per = sp; src = 1'b0;
                pulse_restart();
                clr_stats();
                drive_cycles(4 * (l + 1) * sp);
                check(pc0, 4, "R3");
            end
        end

        cur_tag = "R2";
        limit = 4'd2; src = 1'b1; sys_per = 1; ls_per = 3;
        pulse_restart(); clr_stats(); drive_cycles(27);
        check(pc0, 3, "R2");
        src = 1'b0; sys_per = 0; ls_per = 1;
        pulse_restart(); clr_stats(); drive_cycles(20);
        check(pc0, 0, "R2");

        cur_tag = "R4";
        limit = 4'd3; sys_per = 1; clr_stats();
        for (int i = 0; i < 10; i++) begin pulse_restart(); drive_cycles(2); end
        check(pc0, 0, "R4");
        prime(4); stop = 1'b1; drive_cycles(5); pulse_restart(); drive_cycles(5);
        stop = 1'b0; clr_stats(); drive_cycles(60);
        check(f0, 39, "R4");
        prime(4); stop = 1'b1; drive_cycles(5); stop = 1'b0; drive_cycles(3);
        pulse_restart(); clr_stats(); drive_cycles(60);
        check(f0, 39, "R4");
        check(f1, 22, "R4");

        cur_tag = "R5";
        prime(4); stop = 1'b1; clr_stats(); drive_cycles(50);
        check(pc0, 0, "R5");
        stop = 1'b0; clr_stats(); drive_cycles(60);
        check(f0, 39, "R6");
        check(f1, 22, "R10");
        cur_tag = "R6";
        prime(1); stop = 1'b1; drive_cycles(8); stop = 1'b0; clr_stats(); drive_cycles(60);
        check(f0, 42, "R5");
        check(f1, 25, "R6");

        cur_tag = "R7";
        prime(4); halt = 1'b1; hfe = 1'b1; clr_stats(); drive_cycles(20);
        check(pc0, 0, "R7");
        halt = 1'b0; clr_stats(); drive_cycles(10);
        check(f0, 4, "R7");
        src = 1'b1; ls_per = 2; halt = 1'b1; clr_stats(); drive_cycles(30);
        check(pc0, 0, "R7");
        halt = 1'b0; hfe = 1'b0; src = 1'b0; ls_per = 1;

        cur_tag = "R8";
        prime(4); halt = 1'b1; hfe = 1'b0; clr_stats(); drive_cycles(16);
        check(f0, 4, "R8");
        check(pc0, 2, "R8");
        halt = 1'b0;

        cur_tag = "R9";
        prime(4); stop = 1'b1; halt = 1'b1; hfe = 1'b1; drive_cycles(10);
        stop = 1'b0; halt = 1'b0; clr_stats(); drive_cycles(60);
        check(f0, 39, "R9");
        check(f1, 22, "R10");
        hfe = 1'b0;

        drive_cycles(4);
        done = 1;
        report();
    end
endmodule